// File: doc/BRIEF.md
# Sync Output Conditioner

This block regenerates horizontal and vertical sync outputs for downstream display circuitry. Each of the two channels either passes its synchronized input sync through, or substitutes a sync made by an internal free-running generator. The chosen signal then gets a per-channel output polarity. When a channel's enable is low, its pin carries a plain general-purpose level instead. The free-run generator has two selectable line periods and derives its frame sync by counting lines. A move between pass-through and free-run waits until both candidate signals are inactive, so no shortened pulse reaches the pin.

A third output serves a half-rate sync path. In half mode it toggles on every rising edge of its synchronized input, which gives the input frequency divided by two at 50% duty. Outside half mode it can copy the input with a selectable polarity, or it can act as a general-purpose pin. All inputs are treated as active-high pulses. Every control is a static configuration level driven by a register elsewhere.

Top module: `sync_out_cond`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all three outputs are 0, the divider state is 0 and both channels select pass-through.
- R2: With a channel enable low, that channel's output equals its general-purpose level one clock later.
- R3: In pass-through with the enable high, an input change appears at the output on the third rising clock edge after the input changes. The output equals the input when the polarity bit is 1 and its inverse when the bit is 0.
- R4: In free-run, the H output repeats every HPER0 clocks when `fr_sel` is 0 and every HPER1 clocks when `fr_sel` is 1. Each H pulse is HPW clocks wide.
- R5: In free-run, the V output repeats every LINES line periods and is VPW line periods wide. Its leading edge falls on the same clock as an H leading edge.
- R6: A channel's source changes only on a cycle where both its synchronized input and its free-run signal are inactive. A pass-through pulse that is in progress when free-run is requested completes at full length.
- R7: With `half_en` = 1, `half_out` toggles on each rising edge of `half_in` and shows the change on the fourth rising clock edge after the input rises. A regular input gives an output of twice the period at 50% duty. The divider resets to 0.
- R8: With `half_en` = 1, `half_pol` has no effect on `half_out`.
- R9: With `half_en` = 0 and `no_half` = 1, `half_out` follows `half_in` three clock edges later. It is inverted when `half_pol` = 0 and is an unmodified copy when `half_pol` = 1.
- R10: With `half_en` = 0 and `no_half` = 0, `half_out` equals `gpo_half` one clock later, whatever `half_in` does.
- R11: The polarity bits apply to free-run syncs as well. With polarity 0, the pulse is a low level of the same width and period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Horizontal sync input, active high |
| vs_in | input | 1 | Vertical sync input, active high |
| half_in | input | 1 | Input of the half-rate path, active high |
| en_h | input | 1 | Put the H sync on `hs_out` |
| en_v | input | 1 | Put the V sync on `vs_out` |
| pol_h | input | 1 | H output polarity, 1 = positive |
| pol_v | input | 1 | V output polarity, 1 = positive |
| gpo_h | input | 1 | Level driven on `hs_out` when disabled |
| gpo_v | input | 1 | Level driven on `vs_out` when disabled |
| free_run | input | 1 | Request internally generated syncs |
| fr_sel | input | 1 | Free-run line period select |
| half_en | input | 1 | Divide-by-two mode |
| no_half | input | 1 | Pass-through of the half input when not dividing |
| half_pol | input | 1 | Polarity of the half pass-through, 1 = positive |
| gpo_half | input | 1 | Level on `half_out` when the half path is idle |
| hs_out | output | 1 | Conditioned H sync |
| vs_out | output | 1 | Conditioned V sync |
| half_out | output | 1 | Half-rate path output |

## Verification
The sync and copy paths have three register stages: two synchronizer flops and the output flop. The divider adds a toggle stage, for four. The general-purpose and enable selections act after only the output flop. Each directed task changes an input just after a falling edge and samples on the falling edge that follows the due rising edge. Where latency is specified, it also samples one edge early to confirm the old value is still present. Free-run periods and widths are measured edge to edge, after a settling interval, so that a partial period after a mode or period change is never counted.

// File: rtl/soc_pkg.sv
package soc_pkg;

    typedef enum logic {
        SRC_PASS = 1'b0,
        SRC_FREE = 1'b1
    } src_e;

    localparam int NCHAN = 2;

    function automatic logic apply_pol(input logic s, input logic pos);
        return pos ? s : ~s;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/soc_sync.sv
module soc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/soc_freerun.sv
module soc_freerun
    import soc_pkg::*;
#(
    parameter int HPER0 = 40,
    parameter int HPER1 = 24,
    parameter int HPW   = 4,
    parameter int LINES = 6,
    parameter int VPW   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fr_sel,
    output logic fr_h,
    output logic fr_v
);
    localparam int HMAX = max2(HPER0, HPER1);
    localparam int HW   = $clog2(HMAX + 1);
    localparam int VW   = $clog2(LINES + 1);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic [HW-1:0] last;

    assign last = fr_sel ? HW'(HPER1 - 1) : HW'(HPER0 - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt >= last) begin
            hcnt <= '0;
            vcnt <= (vcnt == VW'(LINES - 1)) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assign fr_h = (hcnt < HW'(HPW));
    assign fr_v = (vcnt < VW'(VPW));
endmodule

// File: rtl/soc_chan.sv
module soc_chan
    import soc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pt,
    input  logic fr,
    input  logic free_run,
    input  logic en,
    input  logic pol,
    input  logic gpo,
    output logic sel_free,
    output logic out
);
    src_e sel;
    logic cur;

    assign cur      = (sel == SRC_FREE) ? fr : pt;
    assign sel_free = (sel == SRC_FREE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SRC_PASS;
            out <= 1'b0;
        end else begin
            if (!pt && !fr)
                sel <= free_run ? SRC_FREE : SRC_PASS;
            out <= en ? apply_pol(cur, pol) : gpo;
        end
    end
endmodule

// File: rtl/soc_half.sv
module soc_half
    import soc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic s,
    input  logic half_en,
    input  logic no_half,
    input  logic half_pol,
    input  logic gpo,
    output logic rise,
    output logic tgl,
    output logic out
);
    logic s_d;

    assign rise = s & ~s_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_d <= 1'b0;
            tgl <= 1'b0;
            out <= 1'b0;
        end else begin
            s_d <= s;
            if (rise)
                tgl <= ~tgl;
            if (half_en)
                out <= tgl;
            else if (no_half)
                out <= apply_pol(s, half_pol);
            else
                out <= gpo;
        end
    end
endmodule

// File: rtl/sync_out_cond.sv
module sync_out_cond
    import soc_pkg::*;
#(
    parameter int HPER0 = 40,
    parameter int HPER1 = 24,
    parameter int HPW   = 4,
    parameter int LINES = 6,
    parameter int VPW   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_in,
    input  logic vs_in,
    input  logic half_in,
    input  logic en_h,
    input  logic en_v,
    input  logic pol_h,
    input  logic pol_v,
    input  logic gpo_h,
    input  logic gpo_v,
    input  logic free_run,
    input  logic fr_sel,
    input  logic half_en,
    input  logic no_half,
    input  logic half_pol,
    input  logic gpo_half,
    output logic hs_out,
    output logic vs_out,
    output logic half_out
);
    logic [2:0]       sync_q;
    logic [NCHAN-1:0] pt_s;
    logic [NCHAN-1:0] fr_s;
    logic [NCHAN-1:0] en_a;
    logic [NCHAN-1:0] pol_a;
    logic [NCHAN-1:0] gpo_a;
    logic [NCHAN-1:0] sel_fr;
    logic [NCHAN-1:0] ch_out;
    logic             fr_h;
    logic             fr_v;
    logic             half_s;
    logic             half_rise;
    logic             half_tgl;

    soc_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({half_in, vs_in, hs_in}),
        .q   (sync_q)
    );

    soc_freerun #(
        .HPER0 (HPER0),
        .HPER1 (HPER1),
        .HPW   (HPW),
        .LINES (LINES),
        .VPW   (VPW)
    ) u_fr (
        .clk    (clk),
        .rst    (rst),
        .fr_sel (fr_sel),
        .fr_h   (fr_h),
        .fr_v   (fr_v)
    );

    assign pt_s   = sync_q[1:0];
    assign half_s = sync_q[2];
    assign fr_s   = {fr_v, fr_h};
    assign en_a   = {en_v, en_h};
    assign pol_a  = {pol_v, pol_h};
    assign gpo_a  = {gpo_v, gpo_h};

    for (genvar i = 0; i < NCHAN; i++) begin : g_chan
        soc_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .pt       (pt_s[i]),
            .fr       (fr_s[i]),
            .free_run (free_run),
            .en       (en_a[i]),
            .pol      (pol_a[i]),
            .gpo      (gpo_a[i]),
            .sel_free (sel_fr[i]),
            .out      (ch_out[i])
        );
    end

    assign hs_out = ch_out[0];
    assign vs_out = ch_out[1];

    soc_half u_half (
        .clk      (clk),
        .rst      (rst),
        .s        (half_s),
        .half_en  (half_en),
        .no_half  (no_half),
        .half_pol (half_pol),
        .gpo      (gpo_half),
        .rise     (half_rise),
        .tgl      (half_tgl),
        .out      (half_out)
    );
endmodule

// File: rtl/soc_chk.sv
module soc_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_h,
    input logic       en_v,
    input logic       gpo_h,
    input logic       gpo_v,
    input logic       hs_out,
    input logic       vs_out,
    input logic       half_en,
    input logic       no_half,
    input logic       half_pol,
    input logic       gpo_half,
    input logic       half_out,
    input logic [1:0] sel_fr,
    input logic [1:0] pt_s,
    input logic [1:0] fr_s,
    input logic       half_s,
    input logic       half_rise,
    input logic       half_tgl
);
    assert_gpo_h_R2: assert property (@(posedge clk) disable iff (rst)
        !en_h |=> hs_out == $past(gpo_h));

    assert_gpo_v_R2: assert property (@(posedge clk) disable iff (rst)
        !en_v |=> vs_out == $past(gpo_v));

    assert_switch_h_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_fr[0]) |-> $past(!pt_s[0] && !fr_s[0]));

    assert_switch_v_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_fr[1]) |-> $past(!pt_s[1] && !fr_s[1]));

    assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        half_rise |=> half_tgl != $past(half_tgl));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !half_rise |=> $stable(half_tgl));

    assert_half_out_R8: assert property (@(posedge clk) disable iff (rst)
        half_en |=> half_out == $past(half_tgl));

    assert_copy_R9: assert property (@(posedge clk) disable iff (rst)
        (!half_en && no_half) |=>
            half_out == ($past(half_pol) ? $past(half_s) : !$past(half_s)));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!half_en && !no_half) |=> half_out == $past(gpo_half));
endmodule

bind sync_out_cond soc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_h      (en_h),
    .en_v      (en_v),
    .gpo_h     (gpo_h),
    .gpo_v     (gpo_v),
    .hs_out    (hs_out),
    .vs_out    (vs_out),
    .half_en   (half_en),
    .no_half   (no_half),
    .half_pol  (half_pol),
    .gpo_half  (gpo_half),
    .half_out  (half_out),
    .sel_fr    (sel_fr),
    .pt_s      (pt_s),
    .fr_s      (fr_s),
    .half_s    (half_s),
    .half_rise (half_rise),
    .half_tgl  (half_tgl)
);

// File: tb/sync_out_cond_tb.sv
module sync_out_cond_tb;
    localparam int HPER0 = 40;
    localparam int HPER1 = 24;
    localparam int HPW   = 4;
    localparam int LINES = 6;
    localparam int VPW   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hs_in = 0, vs_in = 0, half_in = 0;
    logic en_h = 1, en_v = 1, pol_h = 1, pol_v = 1, gpo_h = 0, gpo_v = 0;
    logic free_run = 0, fr_sel = 0;
    logic half_en = 0, no_half = 0, half_pol = 1, gpo_half = 0;
    logic hs_out, vs_out, half_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sync_out_cond #(
        .HPER0 (HPER0), .HPER1 (HPER1), .HPW (HPW), .LINES (LINES), .VPW (VPW)
    ) u_dut (
        .clk (clk), .rst (rst),
        .hs_in (hs_in), .vs_in (vs_in), .half_in (half_in),
        .en_h (en_h), .en_v (en_v), .pol_h (pol_h), .pol_v (pol_v),
        .gpo_h (gpo_h), .gpo_v (gpo_v),
        .free_run (free_run), .fr_sel (fr_sel),
        .half_en (half_en), .no_half (no_half), .half_pol (half_pol),
        .gpo_half (gpo_half),
        .hs_out (hs_out), .vs_out (vs_out), .half_out (half_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic sig(input int which);
        case (which)
            0:       return hs_out;
            1:       return vs_out;
            default: return half_out;
        endcase
    endfunction

    // period between two entries into level act, and cycles spent at act
    task automatic measure(input int which, input logic act,
                           output int per, output int wid);
        logic prev;
        int   guard;
        per = 0; wid = 0; guard = 0;
        prev = sig(which);
        while (!(prev != act && sig(which) == act) && guard < 1000) begin
            prev = sig(which);
            @(negedge clk);
            guard++;
        end
        do begin
            if (sig(which) == act) wid++;
            per++;
            prev = sig(which);
            @(negedge clk);
        end while (!(prev != act && sig(which) == act) && per < 1000);
    endtask

    task automatic t_reset;
        check("R1 hs_out in reset", hs_out, 0);
        check("R1 vs_out in reset", vs_out, 0);
        check("R1 half_out in reset", half_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 hs_out after reset", hs_out, 0);
        check("R1 half_out after reset", half_out, 0);
    endtask

    task automatic t_pass;
        hs_in = 1; vs_in = 1;
        wait_neg(2);
        check("R3 hs not yet at edge 2", hs_out, 0);
        wait_neg(1);
        check("R3 hs at edge 3", hs_out, 1);
        check("R3 vs at edge 3", vs_out, 1);
        pol_h = 0;
        hs_in = 0; vs_in = 0;
        wait_neg(3);
        check("R3 hs inverted polarity", hs_out, 1);
        check("R3 vs follows low", vs_out, 0);
        pol_h = 1;
        wait_neg(2);
    endtask

    task automatic t_gpo;
        en_h = 0; gpo_h = 1; en_v = 0; gpo_v = 0;
        hs_in = 0; vs_in = 1;
        wait_neg(1);
        check("R2 hs gpo high", hs_out, 1);
        wait_neg(4);
        check("R2 vs gpo ignores input", vs_out, 0);
        gpo_h = 0;
        wait_neg(1);
        check("R2 hs gpo low", hs_out, 0);
        en_h = 1; en_v = 1; vs_in = 0;
        wait_neg(4);
    endtask

    task automatic t_freerun;
        int per, wid;
        logic h_prev;
        free_run = 1; fr_sel = 0;
        wait_neg(300);
        measure(0, 1'b1, per, wid);
        check("R4 H period sel0", per, HPER0);
        check("R4 H width", wid, HPW);
        measure(1, 1'b1, per, wid);
        check("R5 V period sel0", per, HPER0 * LINES);
        check("R5 V width", wid, HPER0 * VPW);
        // alignment of V leading edge with an H leading edge
        h_prev = 0;
        while (vs_out != 1'b0) begin h_prev = hs_out; @(negedge clk); end
        while (vs_out != 1'b1) begin h_prev = hs_out; @(negedge clk); end
        check("R5 V rise with H rise", {h_prev, hs_out}, 2'b01);
        fr_sel = 1;
        wait_neg(200);
        measure(0, 1'b1, per, wid);
        check("R4 H period sel1", per, HPER1);
        measure(1, 1'b1, per, wid);
        check("R5 V period sel1", per, HPER1 * LINES);
        pol_h = 0;
        wait_neg(50);
        measure(0, 1'b0, per, wid);
        check("R11 inverted H period", per, HPER1);
        check("R11 inverted H low width", wid, HPW);
        pol_h = 1; fr_sel = 0; free_run = 0;
        wait_neg(400);
        hs_in = 1;
        wait_neg(3);
        check("R6 back to pass-through", hs_out, 1);
        hs_in = 0;
        wait_neg(3);
    endtask

    task automatic t_runt;
        int per, wid, miss;
        hs_in = 1;
        wait_neg(4);
        free_run = 1;
        miss = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (hs_out != 1'b1) miss++;
        end
        check("R6 pass pulse held to full length", miss, 0);
        hs_in = 0;
        measure(0, 1'b1, per, wid);
        check("R6 free-run after boundary period", per, HPER0);
        check("R6 free-run first width", wid, HPW);
        free_run = 0;
        wait_neg(100);
    endtask

    task automatic t_half_div;
        int per, wid;
        half_en = 1; no_half = 0; half_pol = 0;
        half_in = 1;
        wait_neg(3);
        check("R7 no toggle at edge 3", half_out, 0);
        wait_neg(1);
        check("R7 toggle at edge 4", half_out, 1);
        half_in = 0;
        wait_neg(6);
        check("R8 held with half_pol 0", half_out, 1);
        half_in = 1;
        wait_neg(4);
        check("R7 second rise toggles back", half_out, 0);
        half_in = 0;
        wait_neg(4);
        fork
            begin
                for (int k = 0; k < 12; k++) begin
                    half_in = 1; wait_neg(5);
                    half_in = 0; wait_neg(5);
                end
            end
            measure(2, 1'b1, per, wid);
        join
        check("R7 divided period", per, 20);
        check("R7 50 percent duty", wid, 10);
        half_pol = 1;
        wait_neg(2);
    endtask

    task automatic t_half_copy;
        half_en = 0; no_half = 1; half_pol = 1; half_in = 0;
        wait_neg(4);
        half_in = 1;
        wait_neg(2);
        check("R9 copy not yet at edge 2", half_out, 0);
        wait_neg(1);
        check("R9 copy at edge 3", half_out, 1);
        half_pol = 0;
        wait_neg(1);
        check("R9 inverted copy", half_out, 0);
        half_in = 0;
        wait_neg(3);
        check("R9 inverted copy low input", half_out, 1);
    endtask

    task automatic t_half_idle;
        no_half = 0; half_en = 0; gpo_half = 1; half_pol = 1;
        wait_neg(1);
        check("R10 idle gpo high", half_out, 1);
        half_in = 1;
        wait_neg(4);
        check("R10 input ignored", half_out, 1);
        gpo_half = 0;
        wait_neg(1);
        check("R10 idle gpo low", half_out, 0);
        half_in = 0;
        wait_neg(4);
        check("R10 input fall ignored", half_out, 0);
    endtask

    initial begin
        wait_neg(3);
        t_reset();
        t_pass();
        t_gpo();
        t_freerun();
        t_runt();
        t_half_div();
        t_half_copy();
        t_half_idle();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule